// File: doc/BRIEF.md
# Store-to-Load Forwarding Unit

This block keeps a small circular queue of in-flight stores and answers forwarding queries from a two-stage load pipeline. A store enters the queue with its virtual address, physical address, a 2-bit size code and its data (which may arrive later through a separate data-write port). The block derives an 8-bit byte mask from the size and the low three address bits, and spreads the data across the 64-bit word to match. Stores leave the queue in order from the head on a dequeue strobe.

A load query carries both addresses, an 8-bit byte mask and a one-bit-per-entry vector that marks which entries are older than the load. In the query cycle (load stage 1) the block returns a fast per-byte forward mask and a fast data-not-ready flag from the virtual-address match. One cycle later (load stage 2) registered outputs give the final per-byte hit mask and bytes from the physical-address match, with the youngest older store winning each byte. They also give a data-not-ready flag with the queue index of the youngest matching store whose data is missing, and an alias flag raised when the virtual and physical match sets disagree.

Top module: `stfwd_unit`

## Requirements
- R1: Reset clears every entry valid flag and every stage-2 output; a query right after reset finds no hit, no data-not-ready and no alias.
- R2: A store's byte mask is 0x01, 0x03, 0x0F or 0xFF for size codes 00, 01, 10, 11, shifted left by virtual-address bits [2:0] and truncated to 8 bits; byte b of the mask is lane b (data bits 8b+7..8b).
- R3: Store data is spread by size: lane b carries raw data byte (b mod 2^size), so a byte repeats 8 times, a halfword 4 times, a word twice and a doubleword is unchanged.
- R4: An entry matches a load only when the address bits above bit 2 are equal and its byte mask overlaps the load mask; a lane forwards only when both the store and load mask bits are set.
- R5: Only valid entries whose bit is set in the query's older vector take part in matching.
- R6: When several matching stores cover one lane, the youngest (most recently enqueued) of them supplies it in stage 2.
- R7: In the query cycle, the fast mask has lane b set when any virtual-address match covers lane b, and the fast data-not-ready flag is set when any virtual-address match has no data yet.
- R8: Stage-2 outputs appear on the clock edge after the query and reflect the physical-address match: a lane's hit bit is set, and its byte driven, only when its winning store has data; lanes without a hit read zero.
- R9: Stage-2 data-not-ready is set when any physical-address match lacks data, with the index of the youngest such entry; a later data write to that index makes the store forwardable.
- R10: Stage-2 alias is set when the set of entries matching on the virtual address differs from the set matching on the physical address.
- R11: A query with its valid input low leaves the fast outputs and the next stage-2 outputs at zero.
- R12: Entries are allocated in order at the tail and freed in order from the head; an enqueue into a full queue is dropped, and a freed entry no longer forwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Allocate a store at the tail |
| enq_vaddr | input | VA_W | Store virtual address |
| enq_paddr | input | PA_W | Store physical address |
| enq_size | input | 2 | Store size code |
| enq_data | input | 64 | Raw store data (low bytes significant) |
| enq_data_ok | input | 1 | Data is present at enqueue |
| dwr_valid | input | 1 | Write late data into an entry |
| dwr_idx | input | IDX_W | Entry index for the data write |
| dwr_data | input | 64 | Raw late store data |
| deq_valid | input | 1 | Free the head entry |
| q_valid | input | 1 | Load query valid (stage 1) |
| q_vaddr | input | VA_W | Load virtual address |
| q_paddr | input | PA_W | Load physical address |
| q_mask | input | 8 | Load byte mask |
| q_older | input | N | One bit per entry: entry is older than the load |
| f_mask | output | 8 | Stage-1 fast forward mask |
| f_dnr | output | 1 | Stage-1 fast data-not-ready |
| s2_mask | output | 8 | Stage-2 per-lane hit bits |
| s2_data | output | 64 | Stage-2 forwarded lanes |
| s2_dnr | output | 1 | Stage-2 data-not-ready |
| s2_dnr_idx | output | IDX_W | Entry index behind data-not-ready |
| s2_alias | output | 1 | Stage-2 virtual/physical match disagreement |

## Verification
The bench sweeps every size code against every byte offset, where a wrong shift or a missing truncation shows as misplaced or spilled hit lanes and a wrong spreading pattern as wrong bytes. It stacks overlapping stores of different sizes on one granule so that a design picking the oldest or the lowest index, instead of the youngest, returns stale bytes, and it wraps the queue pointers so that an age order tied to raw index breaks. Stores without data, late data writes, and stores whose virtual granule matches while the physical one does not probe the data-not-ready index and the alias flag. A full queue, a dequeue and idle queries show whether dropped or freed entries still forward.

// File: rtl/stfwd_pkg.sv
package stfwd_pkg;
   localparam int LANES  = 8;
   localparam int DATA_W = 64;

   function automatic logic [LANES-1:0] size_mask(input logic [1:0] sz, input logic [2:0] off);
      logic [LANES-1:0] base;
      case (sz)
         2'b00:   base = 8'h01;
         2'b01:   base = 8'h03;
         2'b10:   base = 8'h0F;
         default: base = 8'hFF;
      endcase
      return base << off;
   endfunction

   function automatic logic [DATA_W-1:0] spread(input logic [DATA_W-1:0] d, input logic [1:0] sz);
      case (sz)
         2'b00:   return {8{d[7:0]}};
         2'b01:   return {4{d[15:0]}};
         2'b10:   return {2{d[31:0]}};
         default: return d;
      endcase
   endfunction
endpackage

// File: rtl/stfwd_queue.sv
module stfwd_queue
   import stfwd_pkg::*;
#(
   parameter int N    = 16,
   parameter int VA_W = 32,
   parameter int PA_W = 36,
   localparam int IDX_W = $clog2(N),
   localparam int CNT_W = $clog2(N + 1),
   localparam int VG_W  = VA_W - 3,
   localparam int PG_W  = PA_W - 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         enq_valid,
   input  logic [VA_W-1:0]              enq_vaddr,
   input  logic [PA_W-1:0]              enq_paddr,
   input  logic [1:0]                   enq_size,
   input  logic [DATA_W-1:0]            enq_data,
   input  logic                         enq_data_ok,
   input  logic                         dwr_valid,
   input  logic [IDX_W-1:0]             dwr_idx,
   input  logic [DATA_W-1:0]            dwr_data,
   input  logic                         deq_valid,
   output logic [N-1:0]                 ent_vld,
   output logic [N-1:0]                 ent_dok,
   output logic [N-1:0][VG_W-1:0]       ent_vgran,
   output logic [N-1:0][PG_W-1:0]       ent_pgran,
   output logic [N-1:0][LANES-1:0]      ent_mask,
   output logic [N-1:0][DATA_W-1:0]     ent_data,
   output logic [IDX_W-1:0]             tail_ptr
);
   logic [IDX_W-1:0] head, tail, head_nx, tail_nx;
   logic [CNT_W-1:0] count;
   logic [N-1:0][1:0] ent_size;
   logic enq_fire, deq_fire;

   assign enq_fire = enq_valid && (count != CNT_W'(N));
   assign deq_fire = deq_valid && (count != '0);
   assign tail_ptr = tail;

   generate
      if ((N & (N - 1)) == 0) begin : g_wrap_pow2
         assign head_nx = head + 1'b1;
         assign tail_nx = tail + 1'b1;
      end else begin : g_wrap_cmp
         assign head_nx = (head == IDX_W'(N - 1)) ? '0 : head + 1'b1;
         assign tail_nx = (tail == IDX_W'(N - 1)) ? '0 : tail + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (enq_fire) tail <= tail_nx;
         if (deq_fire) head <= head_nx;
         case ({enq_fire, deq_fire})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_ent
         logic alloc, free, late;
         assign alloc = enq_fire && (tail == IDX_W'(i));
         assign free  = deq_fire && (head == IDX_W'(i));
         assign late  = dwr_valid && (dwr_idx == IDX_W'(i)) && ent_vld[i];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ent_vld[i] <= 1'b0;
               ent_dok[i] <= 1'b0;
            end else if (alloc) begin
               ent_vld[i] <= 1'b1;
               ent_dok[i] <= enq_data_ok;
            end else if (free) begin
               ent_vld[i] <= 1'b0;
               ent_dok[i] <= 1'b0;
            end else if (late) begin
               ent_dok[i] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (alloc) begin
               ent_vgran[i] <= enq_vaddr[VA_W-1:3];
               ent_pgran[i] <= enq_paddr[PA_W-1:3];
               ent_mask[i]  <= size_mask(enq_size, enq_vaddr[2:0]);
               ent_size[i]  <= enq_size;
               ent_data[i]  <= spread(enq_data, enq_size);
            end else if (late && !free) begin
               ent_data[i]  <= spread(dwr_data, ent_size[i]);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/stfwd_match.sv
module stfwd_match
   import stfwd_pkg::*;
#(
   parameter int N    = 16,
   parameter int VG_W = 29,
   parameter int PG_W = 33
) (
   input  logic                    q_valid,
   input  logic [VG_W-1:0]         q_vgran,
   input  logic [PG_W-1:0]         q_pgran,
   input  logic [LANES-1:0]        q_mask,
   input  logic [N-1:0]            q_older,
   input  logic [N-1:0]            ent_vld,
   input  logic [N-1:0]            ent_dok,
   input  logic [N-1:0][VG_W-1:0]  ent_vgran,
   input  logic [N-1:0][PG_W-1:0]  ent_pgran,
   input  logic [N-1:0][LANES-1:0] ent_mask,
   output logic [N-1:0]            vhit,
   output logic [N-1:0]            phit,
   output logic [LANES-1:0]        fast_mask,
   output logic                    fast_dnr,
   output logic                    alias_mis
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_cmp
         logic elig;
         assign elig    = q_valid && ent_vld[i] && q_older[i] && |(ent_mask[i] & q_mask);
         assign vhit[i] = elig && (ent_vgran[i] == q_vgran);
         assign phit[i] = elig && (ent_pgran[i] == q_pgran);
      end
   endgenerate

   always_comb begin
      fast_mask = '0;
      for (int i = 0; i < N; i++) begin
         if (vhit[i]) fast_mask = fast_mask | (ent_mask[i] & q_mask);
      end
   end

   assign fast_dnr  = |(vhit & ~ent_dok);
   assign alias_mis = (vhit != phit);
endmodule

// File: rtl/stfwd_pick.sv
module stfwd_pick
   import stfwd_pkg::*;
#(
   parameter int N = 16,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]             phit,
   input  logic [N-1:0]             ent_dok,
   input  logic [N-1:0][LANES-1:0]  ent_mask,
   input  logic [N-1:0][DATA_W-1:0] ent_data,
   input  logic [LANES-1:0]         q_mask,
   input  logic [IDX_W-1:0]         tail_ptr,
   output logic [LANES-1:0]         sel_mask,
   output logic [DATA_W-1:0]        sel_data,
   output logic                     sel_dnr,
   output logic [IDX_W-1:0]         sel_dnr_idx
);
   // Walk from the newest slot (tail-1) backwards; the first hit is the youngest.
   always_comb begin
      sel_mask = '0;
      sel_data = '0;
      for (int b = 0; b < LANES; b++) begin
         logic found;
         found = 1'b0;
         for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(tail_ptr) + 2 * N - 1 - k) % N;
            if (!found && phit[j] && ent_mask[j][b] && q_mask[b]) begin
               found = 1'b1;
               if (ent_dok[j]) begin
                  sel_mask[b]       = 1'b1;
                  sel_data[8*b +: 8] = ent_data[j][8*b +: 8];
               end
            end
         end
      end
   end

   always_comb begin
      sel_dnr     = 1'b0;
      sel_dnr_idx = '0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = (int'(tail_ptr) + 2 * N - 1 - k) % N;
         if (!sel_dnr && phit[j] && !ent_dok[j]) begin
            sel_dnr     = 1'b1;
            sel_dnr_idx = IDX_W'(j);
         end
      end
   end
endmodule

// File: rtl/stfwd_unit.sv
module stfwd_unit
   import stfwd_pkg::*;
#(
   parameter int N    = 16,
   parameter int VA_W = 32,
   parameter int PA_W = 36,
   localparam int IDX_W = $clog2(N),
   localparam int VG_W  = VA_W - 3,
   localparam int PG_W  = PA_W - 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [VA_W-1:0]   enq_vaddr,
   input  logic [PA_W-1:0]   enq_paddr,
   input  logic [1:0]        enq_size,
   input  logic [63:0]       enq_data,
   input  logic              enq_data_ok,
   input  logic              dwr_valid,
   input  logic [IDX_W-1:0]  dwr_idx,
   input  logic [63:0]       dwr_data,
   input  logic              deq_valid,
   input  logic              q_valid,
   input  logic [VA_W-1:0]   q_vaddr,
   input  logic [PA_W-1:0]   q_paddr,
   input  logic [7:0]        q_mask,
   input  logic [N-1:0]      q_older,
   output logic [7:0]        f_mask,
   output logic              f_dnr,
   output logic [7:0]        s2_mask,
   output logic [63:0]       s2_data,
   output logic              s2_dnr,
   output logic [IDX_W-1:0]  s2_dnr_idx,
   output logic              s2_alias
);
   generate
      if (N < 2) begin : g_bad_depth
         $error("stfwd_unit: N must be at least 2");
      end
      if (VA_W < 4 || PA_W < 4) begin : g_bad_addr
         $error("stfwd_unit: address widths must exceed the 8-byte offset");
      end
   endgenerate

   logic [N-1:0]                 ent_vld, ent_dok, vhit, phit;
   logic [N-1:0][VG_W-1:0]       ent_vgran;
   logic [N-1:0][PG_W-1:0]       ent_pgran;
   logic [N-1:0][LANES-1:0]      ent_mask;
   logic [N-1:0][DATA_W-1:0]     ent_data;
   logic [IDX_W-1:0]             tail_ptr;
   logic [LANES-1:0]             c_mask;
   logic [DATA_W-1:0]            c_data;
   logic                         c_dnr, c_alias;
   logic [IDX_W-1:0]             c_dnr_idx;

   stfwd_queue #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) queue_i (
      .clk, .rst_n, .enq_valid, .enq_vaddr, .enq_paddr, .enq_size, .enq_data,
      .enq_data_ok, .dwr_valid, .dwr_idx, .dwr_data, .deq_valid,
      .ent_vld, .ent_dok, .ent_vgran, .ent_pgran, .ent_mask, .ent_data, .tail_ptr
   );

   stfwd_match #(.N(N), .VG_W(VG_W), .PG_W(PG_W)) match_i (
      .q_valid, .q_vgran(q_vaddr[VA_W-1:3]), .q_pgran(q_paddr[PA_W-1:3]),
      .q_mask, .q_older, .ent_vld, .ent_dok, .ent_vgran, .ent_pgran, .ent_mask,
      .vhit, .phit, .fast_mask(f_mask), .fast_dnr(f_dnr), .alias_mis(c_alias)
   );

   stfwd_pick #(.N(N)) pick_i (
      .phit, .ent_dok, .ent_mask, .ent_data, .q_mask, .tail_ptr,
      .sel_mask(c_mask), .sel_data(c_data), .sel_dnr(c_dnr), .sel_dnr_idx(c_dnr_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s2_mask    <= '0;
         s2_data    <= '0;
         s2_dnr     <= 1'b0;
         s2_dnr_idx <= '0;
         s2_alias   <= 1'b0;
      end else begin
         s2_mask    <= c_mask;
         s2_data    <= c_data;
         s2_dnr     <= c_dnr;
         s2_dnr_idx <= c_dnr_idx;
         s2_alias   <= c_alias;
      end
   end
endmodule

// File: rtl/stfwd_chk.sv
module stfwd_chk #(
   parameter int N = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         q_valid,
   input logic [7:0]   q_mask,
   input logic [N-1:0] q_older,
   input logic [7:0]   f_mask,
   input logic         f_dnr,
   input logic [7:0]   s2_mask,
   input logic         s2_dnr,
   input logic         s2_alias
);
   AST_FAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |-> (f_mask == 8'h00 && !f_dnr));                              // R11
   AST_S2_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |=> (s2_mask == 8'h00 && !s2_dnr && !s2_alias));               // R11
   AST_FAST_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> ((f_mask & ~q_mask) == 8'h00));                             // R4
   AST_S2_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |=> ((s2_mask & ~$past(q_mask)) == 8'h00));                     // R8
   AST_FAST_NO_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
      (q_older == '0) |-> (f_mask == 8'h00 && !f_dnr));                       // R5
   AST_S2_NO_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
      (q_older == '0) |=> (s2_mask == 8'h00 && !s2_dnr && !s2_alias));        // R5
endmodule

bind stfwd_unit stfwd_chk #(.N(N)) chk_i (
   .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_mask(q_mask), .q_older(q_older),
   .f_mask(f_mask), .f_dnr(f_dnr), .s2_mask(s2_mask), .s2_dnr(s2_dnr), .s2_alias(s2_alias)
);

// File: tb/stfwd_unit_tb.sv
module stfwd_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N = 16;
   localparam int VA_W = 32;
   localparam int PA_W = 36;
   localparam int IDX_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enq_valid = 0, enq_data_ok = 0, dwr_valid = 0, deq_valid = 0, q_valid = 0;
   logic [VA_W-1:0] enq_vaddr = '0, q_vaddr = '0;
   logic [PA_W-1:0] enq_paddr = '0, q_paddr = '0;
   logic [1:0] enq_size = '0;
   logic [63:0] enq_data = '0, dwr_data = '0;
   logic [IDX_W-1:0] dwr_idx = '0;
   logic [7:0] q_mask = '0;
   logic [N-1:0] q_older = '0;
   logic [7:0] f_mask, s2_mask;
   logic f_dnr, s2_dnr, s2_alias;
   logic [63:0] s2_data;
   logic [IDX_W-1:0] s2_dnr_idx;

   always #(CLK_PERIOD / 2) clk = ~clk;

   stfwd_unit #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) dut_i (.*);

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   // bench model of queue contents
   bit          m_vld[N];
   bit          m_dok[N];
   logic [VA_W-1:0] m_va[N];
   logic [PA_W-1:0] m_pa[N];
   logic [1:0]  m_sz[N];
   logic [63:0] m_d[N];
   int          m_seq[N];
   int head = 0, tail = 0, count = 0, seqctr = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] smask(input int i);
      int w;
      w = 1 << m_sz[i];
      return 8'(((1 << w) - 1) << m_va[i][2:0]);
   endfunction

   task automatic enq(input logic [VA_W-1:0] va, input logic [PA_W-1:0] pa,
                      input logic [1:0] sz, input logic [63:0] d, input bit ok);
      enq_valid = 1; enq_vaddr = va; enq_paddr = pa; enq_size = sz; enq_data = d; enq_data_ok = ok;
      @(posedge clk);
      if (count < N) begin
         m_vld[tail] = 1; m_dok[tail] = ok; m_va[tail] = va; m_pa[tail] = pa;
         m_sz[tail] = sz; m_d[tail] = d; m_seq[tail] = seqctr++;
         tail = (tail + 1) % N; count++;
      end
      @(negedge clk);
      enq_valid = 0;
   endtask

   task automatic deq();
      deq_valid = 1;
      @(posedge clk);
      if (count > 0) begin
         m_vld[head] = 0; m_dok[head] = 0; head = (head + 1) % N; count--;
      end
      @(negedge clk);
      deq_valid = 0;
   endtask

   task automatic dwr(input int idx, input logic [63:0] d);
      dwr_valid = 1; dwr_idx = IDX_W'(idx); dwr_data = d;
      @(posedge clk);
      if (m_vld[idx]) begin m_dok[idx] = 1; m_d[idx] = d; end
      @(negedge clk);
      dwr_valid = 0;
   endtask

   task automatic flush();
      while (count > 0) deq();
   endtask

   task automatic query(input string req, input bit v, input logic [VA_W-1:0] va,
                        input logic [PA_W-1:0] pa, input logic [7:0] lm, input logic [N-1:0] old);
      logic [7:0] e_fm, e_m;
      logic [63:0] e_d;
      bit e_fd, e_dn, e_al;
      int e_di, best, dseq;
      logic [N-1:0] vm, pm;
      e_fm = 0; e_m = 0; e_d = 0; e_fd = 0; e_dn = 0; e_al = 0; e_di = 0; vm = 0; pm = 0;
      for (int i = 0; i < N; i++) begin
         if (v && m_vld[i] && old[i] && (smask(i) & lm) != 0) begin
            vm[i] = (m_va[i][VA_W-1:3] == va[VA_W-1:3]);
            pm[i] = (m_pa[i][PA_W-1:3] == pa[PA_W-1:3]);
            if (vm[i]) begin e_fm |= smask(i) & lm; if (!m_dok[i]) e_fd = 1; end
         end
      end
      for (int b = 0; b < 8; b++) begin
         best = -1;
         for (int i = 0; i < N; i++)
            if (pm[i] && smask(i)[b] && lm[b] && (best < 0 || m_seq[i] > m_seq[best])) best = i;
         if (best >= 0 && m_dok[best]) begin
            e_m[b] = 1;
            e_d[8*b +: 8] = m_d[best][8*(b % (1 << m_sz[best])) +: 8];
         end
      end
      dseq = -1;
      for (int i = 0; i < N; i++)
         if (pm[i] && !m_dok[i] && m_seq[i] > dseq) begin dseq = m_seq[i]; e_dn = 1; e_di = i; end
      e_al = (vm != pm);
      q_valid = v; q_vaddr = va; q_paddr = pa; q_mask = lm; q_older = old;
      #1;
      chk({req, " fast mask"}, 64'(f_mask), 64'(e_fm));
      chk({req, " fast dnr"}, 64'(f_dnr), 64'(e_fd));
      @(posedge clk);
      @(negedge clk);
      chk({req, " s2 mask"}, 64'(s2_mask), 64'(e_m));
      chk({req, " s2 data"}, s2_data, e_d);
      chk({req, " s2 dnr"}, 64'(s2_dnr), 64'(e_dn));
      if (e_dn) chk({req, " s2 dnr idx"}, 64'(s2_dnr_idx), 64'(e_di));
      chk({req, " s2 alias"}, 64'(s2_alias), 64'(e_al));
      q_valid = 0; q_older = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] all_old;
      int slot;
      all_old = '1;
      for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_dok[i] = 0; m_seq[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      chk("R1 s2 mask after reset", 64'(s2_mask), 0);
      chk("R1 s2 dnr after reset", 64'(s2_dnr), 0);
      query("R1", 1, 32'h0, 36'h0, 8'hFF, all_old);

      // R2/R3: every size against every offset
      for (int sz = 0; sz < 4; sz++)
         for (int off = 0; off < 8; off++) begin
            flush();
            slot = tail;
            enq(32'h1000 + off, 36'h8_0000 + off, 2'(sz), {$urandom, $urandom}, 1);
            query("R2/R3", 1, 32'h1000, 36'h8_0000, 8'hFF, N'(1) << slot);
         end

      // R4: granule compare and lane AND
      flush();
      enq(32'h2000, 36'h9000, 2'b11, 64'h8877665544332211, 1);
      query("R4 other granule", 1, 32'h2008, 36'h9008, 8'hFF, all_old);
      query("R4 partial load mask", 1, 32'h2004, 36'h9004, 8'h30, all_old);
      query("R4 no overlap", 1, 32'h2000, 36'h9000, 8'h00, all_old);
      // R5: older vector excludes
      query("R5 not older", 1, 32'h2000, 36'h9000, 8'hFF, '0);

      // R6: youngest wins, with pointers wrapped
      flush();
      enq(32'h3002, 36'hA002, 2'b00, 64'hAA, 1);
      enq(32'h3002, 36'hA002, 2'b01, 64'hBBCC, 1);
      enq(32'h3003, 36'hA003, 2'b00, 64'hDD, 1);
      enq(32'h3000, 36'hA000, 2'b10, 64'h11223344, 1);
      query("R6 youngest", 1, 32'h3000, 36'hA000, 8'hFF, all_old);
      query("R6 youngest partial older", 1, 32'h3000, 36'hA000, 8'hFF,
            all_old & ~(N'(1) << ((tail + N - 1) % N)));

      // R7/R9: pending data, then late write
      flush();
      enq(32'h4000, 36'hB000, 2'b00, 64'h5A, 1);
      slot = tail;
      enq(32'h4000, 36'hB000, 2'b11, 64'h0, 0);
      query("R7/R9 pending", 1, 32'h4000, 36'hB000, 8'hFF, all_old);
      dwr(slot, 64'hCAFEF00DDEADBEEF);
      query("R9 after data write", 1, 32'h4000, 36'hB000, 8'hFF, all_old);

      // R10: virtual match, physical mismatch
      flush();
      enq(32'h5000, 36'hC000, 2'b11, 64'h0102030405060708, 1);
      query("R10 alias", 1, 32'h5000, 36'hD000, 8'hFF, all_old);
      // R11: idle query
      query("R11 idle", 0, 32'h5000, 36'hC000, 8'hFF, all_old);

      // R12: full queue drops enqueue, dequeue frees
      flush();
      for (int i = 0; i < N; i++) enq(32'h6000 + 8 * i, 36'hE000 + 8 * i, 2'b11, 64'(i + 1), 1);
      slot = head;
      enq(32'h7000, 36'hF000, 2'b11, 64'h77, 1);
      query("R12 dropped enqueue", 1, 32'h7000, 36'hF000, 8'hFF, all_old);
      query("R12 head live", 1, 32'h6000, 36'hE000, 8'hFF, all_old);
      deq();
      query("R12 head freed", 1, 32'h6000, 36'hE000, 8'hFF, all_old);
      query("R12 next live", 1, 32'h6008, 36'hE008, 8'hFF, all_old);

      // random mix across two granules with aliasing
      flush();
      for (int it = 0; it < 400; it++) begin
         int op;
         logic [VA_W-1:0] va;
         logic [PA_W-1:0] pa;
         op = $urandom % 8;
         va = 32'h100 * 8 + 8 * ($urandom % 2) + ($urandom % 8);
         pa = 36'h500 * 8 + 8 * (($urandom % 4 == 0) ? ($urandom % 2) : ((va >> 3) & 1)) + va[2:0];
         if (op < 3) begin
            if (count == N) deq();
            enq(va, pa, 2'($urandom), {$urandom, $urandom}, ($urandom % 3) != 0);
         end else if (op == 3) begin
            deq();
         end else if (op == 4) begin
            dwr($urandom % N, {$urandom, $urandom});
         end else begin
            query("R6/R7/R8/R9/R10 random", ($urandom % 8) != 0, va, pa,
                  8'($urandom), N'($urandom));
         end
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule